// File: doc/BRIEF.md
# Linked-List DMA Descriptor Sequencer

This block is a single-channel copy engine driven by a chain of descriptors held in system memory. Software stores a descriptor address in the head register and writes the run bit. The engine reads the five-word descriptor, loads its channel registers from it, and copies the buffer one 32-bit word at a time from the source to the destination. It then writes the updated control word back into the descriptor and moves on to the next descriptor. The chain ends after a descriptor whose next pointer is zero.

Descriptors are read and written back through a memory master port. Buffer words move through a separate data port. Three sticky interrupt flags report progress: buffer complete, chain complete and error. Software reads and clears them through one status register. The engine does not wait for software to clear the buffer flag before it continues along the chain. Software learns that a buffer has finished by polling the done bit in the descriptor in memory.

Top module: `lldma_top`

## Requirements
- R1: The register index is `reg_addr`: 0 run control, 1 head pointer, 2 status, 3..7 the live source, destination, next pointer, control A and control B. A write of 1 to bit 0 of register 0 starts the channel, but only while it is idle. Register 0 reads back 1 in bit 0 for as long as the channel runs. While the channel runs, writes to registers 0 and 1 are ignored.
- R2: A descriptor is five words at base+0, +4, +8, +12 and +16, holding in that order the source address, destination address, next pointer, control A and control B. The engine reads them in that order and loads all five channel registers. The first descriptor comes from the head pointer.
- R3: Bits 15:0 of control A give the buffer length in words. Each word is read at the source address and then written to the destination address, and both addresses then advance by 4. A length of 0 moves no data.
- R4: After each buffer, exactly one memory write goes to base+12 of that descriptor. Its value is bit 31 set, bits 30:16 as fetched, and bits 15:0 the remaining count, which is 0 after a complete buffer.
- R5: After the write-back handshake completes, the read of the next descriptor starts on the following cycle. The pending buffer flag does not delay it.
- R6: When the finished descriptor has a next pointer of 0, the engine sets the chain-complete flag, clears run bit 0 and issues no further requests.
- R7: `beat_ack` pulses for exactly one cycle for each word written to the destination.
- R8: Status bit 0 is buffer complete, bit 1 is chain complete and bit 2 is error. A read of register 2 returns the bits and clears them. A bit stays set until it is read, and a set event in the same cycle as a read wins. `irq_buf`, `irq_end` and `irq_err` follow bits 0, 1 and 2.
- R9: An error response (`mem_err` or `dm_err` with its ack) stops the channel, sets the error flag and skips the write-back. This applies to a descriptor word, a data beat or the write-back itself.
- R10: A request on either port holds its address, direction and data until it is acknowledged. The two ports never request in the same cycle.
- R11: After synchronous reset the channel is idle, all flags are clear and neither port requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status on read) |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Descriptor port request |
| mem_we | output | 1 | Descriptor port write (write-back) |
| mem_addr | output | 32 | Descriptor port byte address |
| mem_wdata | output | 32 | Write-back word |
| mem_rdata | input | 32 | Descriptor word returned with ack |
| mem_ack | input | 1 | Descriptor port handshake complete |
| mem_err | input | 1 | Error response, valid with mem_ack |
| dm_req | output | 1 | Data port request |
| dm_we | output | 1 | Data port write |
| dm_addr | output | 32 | Data port byte address |
| dm_wdata | output | 32 | Data port write word |
| dm_rdata | input | 32 | Data port read word, valid with dm_ack |
| dm_ack | input | 1 | Data port handshake complete |
| dm_err | input | 1 | Error response, valid with dm_ack |
| beat_ack | output | 1 | One-cycle pulse per word delivered |
| irq_buf | output | 1 | Buffer complete flag |
| irq_end | output | 1 | Chain complete flag |
| irq_err | output | 1 | Error flag |

## Verification
The assertions assume that both memory ports answer only while a request is pending, that an error response always comes with its ack, and that software does not read the status register in the same cycle in which it expects a flag to be set. The bench memory model acknowledges one cycle after it sees a request and drops the ack for one cycle after each handshake. It raises an error only at one chosen address, and only together with an ack. All register accesses happen at the falling edge, away from the handshake edges.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

    localparam int WORD_W     = 32;
    localparam int LEN_W      = 16;
    localparam int DESC_WORDS = 5;
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam int STEP       = WORD_W / 8;
    localparam int CTLA_IDX   = 3;
    localparam int DONE_BIT   = WORD_W - 1;
    localparam int STS_W      = 3;
    localparam int STS_BUF    = 0;
    localparam int STS_END    = 1;
    localparam int STS_ERR    = 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        RA_RUN  = 3'd0,
        RA_HEAD = 3'd1,
        RA_STAT = 3'd2,
        RA_SRC  = 3'd3,
        RA_DST  = 3'd4,
        RA_NEXT = 3'd5,
        RA_CTLA = 3'd6,
        RA_CTLB = 3'd7
    } reg_idx_e;

    typedef struct packed {
        word_t src;
        word_t dst;
        word_t nxt;
        word_t ctla;
        word_t ctlb;
    } desc_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FETCH,
        SQ_GO,
        SQ_MOVE,
        SQ_WBACK
    } sq_state_e;

    typedef enum logic [1:0] {
        MV_IDLE,
        MV_RD,
        MV_WR
    } mv_state_e;

    function automatic word_t word_addr(word_t base, logic [IDX_W-1:0] idx);
        return base + {{(WORD_W-IDX_W-2){1'b0}}, idx, 2'b00};
    endfunction

    function automatic desc_t desc_put(desc_t d, logic [IDX_W-1:0] idx, word_t w);
        desc_t r;
        r = d;
        case (idx)
            3'd0:    r.src  = w;
            3'd1:    r.dst  = w;
            3'd2:    r.nxt  = w;
            3'd3:    r.ctla = w;
            default: r.ctlb = w;
        endcase
        return r;
    endfunction

    function automatic word_t wback_word(word_t ctla);
        word_t r;
        r = ctla;
        r[DONE_BIT] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/lldma_regs.sv
module lldma_regs
    import lldma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  word_t            reg_wdata,
    output word_t            reg_rdata,
    input  logic             busy,
    input  desc_t            chan,
    input  logic             set_buf,
    input  logic             set_end,
    input  logic             set_err,
    output word_t            head,
    output logic             start,
    output logic [STS_W-1:0] sts
);

    reg_idx_e         ra;
    logic [STS_W-1:0] set_v;
    logic [STS_W-1:0] clr_v;

    assign ra    = reg_idx_e'(reg_addr);
    assign start = reg_wr && (ra == RA_RUN) && reg_wdata[0] && !busy;

    always_comb begin
        set_v          = '0;
        set_v[STS_BUF] = set_buf;
        set_v[STS_END] = set_end;
        set_v[STS_ERR] = set_err;
        clr_v          = {STS_W{reg_rd && (ra == RA_STAT)}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            sts  <= '0;
        end else begin
            if (reg_wr && (ra == RA_HEAD) && !busy)
                head <= reg_wdata;
            sts <= (sts & ~clr_v) | set_v;
        end
    end

    always_comb begin
        case (ra)
            RA_RUN:  reg_rdata = {{(WORD_W-1){1'b0}}, busy};
            RA_HEAD: reg_rdata = head;
            RA_STAT: reg_rdata = {{(WORD_W-STS_W){1'b0}}, sts};
            RA_SRC:  reg_rdata = chan.src;
            RA_DST:  reg_rdata = chan.dst;
            RA_NEXT: reg_rdata = chan.nxt;
            RA_CTLA: reg_rdata = chan.ctla;
            default: reg_rdata = chan.ctlb;
        endcase
    end

endmodule

// File: rtl/lldma_mover.sv
module lldma_mover
    import lldma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  word_t            src,
    input  word_t            dst,
    input  logic [LEN_W-1:0] remain,
    output logic             dm_req,
    output logic             dm_we,
    output word_t            dm_addr,
    output word_t            dm_wdata,
    input  word_t            dm_rdata,
    input  logic             dm_ack,
    input  logic             dm_err,
    output logic             adv,
    output logic             fin,
    output logic             err
);

    mv_state_e st;
    word_t     hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= MV_IDLE;
            hold <= '0;
            fin  <= 1'b0;
        end else begin
            fin <= 1'b0;
            case (st)
                MV_IDLE: begin
                    if (go) begin
                        if (remain == '0) fin <= 1'b1;
                        else              st  <= MV_RD;
                    end
                end
                MV_RD: begin
                    if (dm_ack) begin
                        if (dm_err) begin
                            st <= MV_IDLE;
                        end else begin
                            hold <= dm_rdata;
                            st   <= MV_WR;
                        end
                    end
                end
                MV_WR: begin
                    if (dm_ack) begin
                        if (dm_err) begin
                            st <= MV_IDLE;
                        end else if (remain == LEN_W'(1)) begin
                            fin <= 1'b1;
                            st  <= MV_IDLE;
                        end else begin
                            st <= MV_RD;
                        end
                    end
                end
                default: st <= MV_IDLE;
            endcase
        end
    end

    always_comb begin
        dm_req   = (st != MV_IDLE);
        dm_we    = (st == MV_WR);
        dm_addr  = (st == MV_WR) ? dst : src;
        dm_wdata = hold;
        adv      = (st == MV_WR) && dm_ack && !dm_err;
        err      = (st != MV_IDLE) && dm_ack && dm_err;
    end

endmodule

// File: rtl/lldma_seq.sv
module lldma_seq
    import lldma_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  word_t head,
    output desc_t chan,
    output logic  busy,
    output logic  mem_req,
    output logic  mem_we,
    output word_t mem_addr,
    output word_t mem_wdata,
    input  word_t mem_rdata,
    input  logic  mem_ack,
    input  logic  mem_err,
    output logic  mv_go,
    input  logic  mv_adv,
    input  logic  mv_fin,
    input  logic  mv_err,
    output logic  set_buf,
    output logic  set_end,
    output logic  set_err
);

    sq_state_e        st;
    word_t            base;
    logic [IDX_W-1:0] idx;
    logic             hs_ok;
    logic             hs_bad;

    assign hs_ok  = mem_req && mem_ack && !mem_err;
    assign hs_bad = mem_req && mem_ack && mem_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SQ_IDLE;
            base <= '0;
            idx  <= '0;
            chan <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        base <= head;
                        idx  <= '0;
                        st   <= SQ_FETCH;
                    end
                end
                SQ_FETCH: begin
                    if (hs_bad) begin
                        st <= SQ_IDLE;
                    end else if (hs_ok) begin
                        chan <= desc_put(chan, idx, mem_rdata);
                        if (idx == IDX_W'(DESC_WORDS-1)) st <= SQ_GO;
                        else                             idx <= idx + 1'b1;
                    end
                end
                SQ_GO: st <= SQ_MOVE;
                SQ_MOVE: begin
                    if (mv_adv) begin
                        chan.src             <= chan.src + WORD_W'(STEP);
                        chan.dst             <= chan.dst + WORD_W'(STEP);
                        chan.ctla[LEN_W-1:0] <= chan.ctla[LEN_W-1:0] - 1'b1;
                    end
                    if (mv_err)      st <= SQ_IDLE;
                    else if (mv_fin) st <= SQ_WBACK;
                end
                SQ_WBACK: begin
                    if (hs_bad) begin
                        st <= SQ_IDLE;
                    end else if (hs_ok) begin
                        if (chan.nxt == '0) begin
                            st <= SQ_IDLE;
                        end else begin
                            base <= chan.nxt;
                            idx  <= '0;
                            st   <= SQ_FETCH;
                        end
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (st != SQ_IDLE);
        mem_req   = (st == SQ_FETCH) || (st == SQ_WBACK);
        mem_we    = (st == SQ_WBACK);
        mem_addr  = (st == SQ_WBACK) ? word_addr(base, IDX_W'(CTLA_IDX))
                                     : word_addr(base, idx);
        mem_wdata = wback_word(chan.ctla);
        mv_go     = (st == SQ_GO);
        set_buf   = (st == SQ_WBACK) && hs_ok;
        set_end   = (st == SQ_WBACK) && hs_ok && (chan.nxt == '0);
        set_err   = hs_bad || mv_err;
    end

endmodule

// File: rtl/lldma_top.sv
module lldma_top
    import lldma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack,
    input  logic        mem_err,
    output logic        dm_req,
    output logic        dm_we,
    output logic [31:0] dm_addr,
    output logic [31:0] dm_wdata,
    input  logic [31:0] dm_rdata,
    input  logic        dm_ack,
    input  logic        dm_err,
    output logic        beat_ack,
    output logic        irq_buf,
    output logic        irq_end,
    output logic        irq_err
);

    desc_t            chan;
    word_t            head;
    logic             start, busy;
    logic             mv_go, mv_adv, mv_fin, mv_err;
    logic             set_buf, set_end, set_err;
    logic [STS_W-1:0] sts;

    lldma_regs u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .chan(chan),
        .set_buf(set_buf), .set_end(set_end), .set_err(set_err),
        .head(head), .start(start), .sts(sts)
    );

    lldma_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .head(head),
        .chan(chan), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .mem_err(mem_err),
        .mv_go(mv_go), .mv_adv(mv_adv), .mv_fin(mv_fin), .mv_err(mv_err),
        .set_buf(set_buf), .set_end(set_end), .set_err(set_err)
    );

    lldma_mover u_mover (
        .clk(clk), .rst(rst), .go(mv_go),
        .src(chan.src), .dst(chan.dst), .remain(chan.ctla[LEN_W-1:0]),
        .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr),
        .dm_wdata(dm_wdata), .dm_rdata(dm_rdata),
        .dm_ack(dm_ack), .dm_err(dm_err),
        .adv(mv_adv), .fin(mv_fin), .err(mv_err)
    );

    assign beat_ack = mv_adv;
    assign irq_buf  = sts[STS_BUF];
    assign irq_end  = sts[STS_END];
    assign irq_err  = sts[STS_ERR];

endmodule

// File: rtl/lldma_chk.sv
module lldma_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_rd,
    input logic [2:0]  reg_addr,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        mem_err,
    input logic        dm_req,
    input logic        dm_we,
    input logic [31:0] dm_addr,
    input logic [31:0] dm_wdata,
    input logic        dm_ack,
    input logic        dm_err,
    input logic        beat_ack,
    input logic        irq_buf,
    input logic        irq_end,
    input logic        irq_err
);

    logic stat_rd;
    assign stat_rd = reg_rd && (reg_addr == 3'd2);

    p_mem_hold_r10: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    p_dm_hold_r10: assert property (@(posedge clk) disable iff (rst)
        dm_req && !dm_ack |=> dm_req && $stable(dm_addr) && $stable(dm_we) && $stable(dm_wdata));

    p_one_port_r10: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && dm_req));

    p_wback_word_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> mem_wdata[31] && (mem_wdata[15:0] == 16'h0));

    p_end_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_end) |-> $past(mem_req && mem_we && mem_ack && !mem_err));

    p_err_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_err) |-> $past((mem_ack && mem_err) || (dm_ack && dm_err)));

    p_buf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        irq_buf && !stat_rd |=> irq_buf);

    p_end_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        irq_end && !stat_rd |=> irq_end);

    p_beat_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        beat_ack |=> !beat_ack);

endmodule

bind lldma_top lldma_chk u_chk (
    .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr),
    .dm_wdata(dm_wdata), .dm_ack(dm_ack), .dm_err(dm_err),
    .beat_ack(beat_ack), .irq_buf(irq_buf), .irq_end(irq_end), .irq_err(irq_err)
);

// File: tb/lldma_top_tb_top.sv
`timescale 1ns/1ps
module lldma_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, dm_req, dm_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, dm_addr, dm_wdata, dm_rdata;
    logic        mem_ack, mem_err, dm_ack, dm_err;
    logic        beat_ack, irq_buf, irq_end, irq_err;

    always #10 clk = ~clk;

    lldma_top dut_i (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .mem_err(mem_err),
        .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr),
        .dm_wdata(dm_wdata), .dm_rdata(dm_rdata),
        .dm_ack(dm_ack), .dm_err(dm_err),
        .beat_ack(beat_ack), .irq_buf(irq_buf), .irq_end(irq_end), .irq_err(irq_err)
    );

    // ---------------- memory model ----------------
    logic [31:0] ram [0:255];
    logic        m_ack_q = 1'b0, d_ack_q = 1'b0;
    logic [31:0] err_maddr = 32'hFFFF_FFFF, err_daddr = 32'hFFFF_FFFF;
    logic [31:0] log_addr [0:63];
    logic        log_we   [0:63];
    int          log_cyc  [0:63];
    int          log_n = 0;
    int          beats = 0;
    int          cyc = 0;
    int          proto_viol = 0;
    logic        p_mreq = 1'b0, p_mack = 1'b0, p_mwe = 1'b0;
    logic [31:0] p_maddr = 32'h0;
    logic        p_dreq = 1'b0, p_dack = 1'b0, p_dwe = 1'b0;
    logic [31:0] p_daddr = 32'h0;

    assign mem_ack   = m_ack_q;
    assign dm_ack    = d_ack_q;
    assign mem_err   = m_ack_q && (mem_addr == err_maddr);
    assign dm_err    = d_ack_q && (dm_addr == err_daddr);
    assign mem_rdata = ram[mem_addr[9:2]];
    assign dm_rdata  = ram[dm_addr[9:2]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_ack_q <= 1'b0;
            d_ack_q <= 1'b0;
        end else begin
            m_ack_q <= mem_req && !m_ack_q;
            d_ack_q <= dm_req && !d_ack_q;
            if (m_ack_q && mem_req) begin
                if (log_n < 64) begin
                    log_addr[log_n] <= mem_addr;
                    log_we[log_n]   <= mem_we;
                    log_cyc[log_n]  <= cyc;
                end
                log_n <= log_n + 1;
                if (mem_we && !mem_err) ram[mem_addr[9:2]] <= mem_wdata;
            end
            if (d_ack_q && dm_req && dm_we && !dm_err) ram[dm_addr[9:2]] <= dm_wdata;
            if (beat_ack) beats <= beats + 1;
            // R10 protocol monitor
            if (mem_req && dm_req) proto_viol <= proto_viol + 1;
            if (p_mreq && !p_mack && (!mem_req || mem_addr != p_maddr || mem_we != p_mwe))
                proto_viol <= proto_viol + 1;
            if (p_dreq && !p_dack && (!dm_req || dm_addr != p_daddr || dm_we != p_dwe))
                proto_viol <= proto_viol + 1;
        end
        p_mreq <= mem_req; p_mack <= m_ack_q; p_mwe <= mem_we; p_maddr <= mem_addr;
        p_dreq <= dm_req;  p_dack <= d_ack_q; p_dwe <= dm_we;  p_daddr <= dm_addr;
    end

    // ---------------- bookkeeping ----------------
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic clear_ram();
        for (int i = 0; i < 256; i++) ram[i] = 32'hDEAD_0000 | i;
    endtask

    task automatic put_desc(input logic [31:0] b, input logic [31:0] s, input logic [31:0] d,
                            input logic [31:0] n, input logic [31:0] ca, input logic [31:0] cb);
        ram[b[9:2]]     = s;
        ram[b[9:2] + 1] = d;
        ram[b[9:2] + 2] = n;
        ram[b[9:2] + 3] = ca;
        ram[b[9:2] + 4] = cb;
    endtask

    task automatic prep();
        logic [31:0] t;
        reg_read(3'd2, t);
        @(negedge clk);
        log_n = 0;
        beats = 0;
    endtask

    task automatic launch(input logic [31:0] h);
        reg_write(3'd1, h);
        reg_write(3'd0, 32'h1);
    endtask

    task automatic wait_stop(input string req);
        int n;
        n = 0;
        while (!irq_end && !irq_err && n < 5000) begin
            @(negedge clk);
            n++;
        end
        checks++;
        if (n >= 5000) begin
            errors++;
            $display("FAIL %s channel did not stop actual=running expected=stopped", req);
        end
        repeat (4) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [31:0] v;
        check("R11", "mem_req", {31'b0, mem_req}, 32'h0);
        check("R11", "dm_req", {31'b0, dm_req}, 32'h0);
        check("R11", "irq", {29'b0, irq_err, irq_end, irq_buf}, 32'h0);
        reg_read(3'd0, v); check("R11", "run reg", v, 32'h0);
        reg_read(3'd2, v); check("R11", "status", v, 32'h0);
    endtask

    task automatic t_single();
        logic [31:0] v;
        clear_ram();
        put_desc(32'h100, 32'h200, 32'h300, 32'h0, 32'h0055_0003, 32'hABCD_0001);
        prep();
        launch(32'h100);
        wait_stop("R6");
        for (int i = 0; i < 5; i++) begin
            check("R2", "fetch address", log_addr[i], 32'h100 + 4 * i);
            check("R2", "fetch is read", {31'b0, log_we[i]}, 32'h0);
        end
        check("R4", "write-back address", log_addr[5], 32'h10C);
        check("R4", "write-back direction", {31'b0, log_we[5]}, 32'h1);
        check("R4", "write-back word", ram[32'h10C >> 2], 32'h8055_0000);
        check("R4", "single write-back", log_n, 6);
        for (int i = 0; i < 3; i++)
            check("R3", "dst word", ram[(32'h300 >> 2) + i], 32'hDEAD_0080 + i);
        check("R3", "word after buffer untouched", ram[(32'h30C >> 2)], 32'hDEAD_00C3);
        check("R7", "beat count", beats, 3);
        reg_read(3'd3, v); check("R3", "live src", v, 32'h20C);
        reg_read(3'd4, v); check("R3", "live dst", v, 32'h30C);
        reg_read(3'd5, v); check("R2", "live next", v, 32'h0);
        reg_read(3'd6, v); check("R2", "live ctla", v, 32'h0055_0000);
        reg_read(3'd7, v); check("R2", "live ctlb", v, 32'hABCD_0001);
        reg_read(3'd1, v); check("R1", "head", v, 32'h100);
        reg_read(3'd0, v); check("R6", "run bit cleared", v, 32'h0);
        check("R8", "irq lines", {29'b0, irq_err, irq_end, irq_buf}, 32'h3);
        reg_read(3'd2, v); check("R8", "status read", v, 32'h3);
        reg_read(3'd2, v); check("R8", "status cleared", v, 32'h0);
        check("R8", "irq after clear", {29'b0, irq_err, irq_end, irq_buf}, 32'h0);
    endtask

    task automatic t_chain();
        logic [31:0] v;
        clear_ram();
        put_desc(32'h100, 32'h200, 32'h300, 32'h140, 32'h0011_0002, 32'h0);
        put_desc(32'h140, 32'h240, 32'h340, 32'h180, 32'h0022_0000, 32'h0);
        put_desc(32'h180, 32'h280, 32'h380, 32'h0,   32'h0033_0004, 32'h0);
        prep();
        launch(32'h100);
        wait_stop("R5");
        check("R5", "access count", log_n, 18);
        check("R5", "second descriptor base", log_addr[6], 32'h140);
        check("R5", "next fetch follows write-back", log_cyc[6] - log_cyc[5], 2);
        check("R5", "third descriptor base", log_addr[12], 32'h180);
        check("R4", "wb 1", ram[32'h10C >> 2], 32'h8011_0000);
        check("R4", "wb 2", ram[32'h14C >> 2], 32'h8022_0000);
        check("R4", "wb 3", ram[32'h18C >> 2], 32'h8033_0000);
        check("R3", "zero-length buffer untouched", ram[32'h340 >> 2], 32'hDEAD_00D0);
        check("R3", "buf1 last word", ram[(32'h300 >> 2) + 1], 32'hDEAD_0081);
        check("R3", "buf3 last word", ram[(32'h380 >> 2) + 3], 32'hDEAD_00A3);
        check("R7", "beat count", beats, 6);
        reg_read(3'd2, v); check("R8", "status", v, 32'h3);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        clear_ram();
        put_desc(32'h100, 32'h200, 32'h300, 32'h0, 32'h0000_0014, 32'h0);
        prep();
        launch(32'h100);
        repeat (10) @(negedge clk);
        reg_write(3'd1, 32'h1C0);
        reg_write(3'd0, 32'h0);
        reg_read(3'd0, v); check("R1", "run bit while busy", v, 32'h1);
        reg_read(3'd1, v); check("R1", "head write ignored", v, 32'h100);
        wait_stop("R1");
        check("R1", "buffer fully moved", beats, 20);
        check("R1", "last word moved", ram[(32'h300 >> 2) + 19], 32'hDEAD_0093);
        reg_read(3'd0, v); check("R6", "run bit idle", v, 32'h0);
    endtask

    task automatic t_fetch_err();
        logic [31:0] v;
        clear_ram();
        put_desc(32'h100, 32'h200, 32'h300, 32'h0, 32'h0000_0002, 32'h0);
        prep();
        err_maddr = 32'h108;
        launch(32'h100);
        wait_stop("R9");
        repeat (10) @(negedge clk);
        check("R9", "accesses before stop", log_n, 3);
        check("R9", "no beats", beats, 0);
        check("R9", "ports idle", {30'b0, mem_req, dm_req}, 32'h0);
        reg_read(3'd0, v); check("R9", "run bit", v, 32'h0);
        reg_read(3'd2, v); check("R9", "status", v, 32'h4);
        err_maddr = 32'hFFFF_FFFF;
    endtask

    task automatic t_data_err();
        logic [31:0] v;
        clear_ram();
        put_desc(32'h100, 32'h200, 32'h300, 32'h0, 32'h0000_0003, 32'h0);
        prep();
        err_daddr = 32'h304;
        launch(32'h100);
        wait_stop("R9");
        repeat (10) @(negedge clk);
        check("R9", "beats before error", beats, 1);
        check("R9", "no write-back", log_n, 5);
        check("R9", "descriptor untouched", ram[32'h10C >> 2], 32'h0000_0003);
        reg_read(3'd2, v); check("R9", "status", v, 32'h4);
        err_daddr = 32'hFFFF_FFFF;
    endtask

    initial begin
        clear_ram();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_chain();
        t_busy_ignore();
        t_fetch_err();
        t_data_err();
        check("R10", "protocol violations", proto_viol, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule